// File: doc/BRIEF.md
# Operand Descriptor Access Checker

This block sits beside the execute stage of a processor whose operands are each described by a packed 32-bit descriptor word. In one clock it decides whether the requested access to an operand is legal and forms the operand's effective data address. If the reference has not been resolved yet, it raises a trap request instead of a grant. A single prioritized fault code tells the trap logic why an access was refused.

Each request carries four things: the descriptor, a write strobe, the requester's relation to the class that owns the operand, and the operand kind that the instruction expects. The bases of the instance and class data spaces come in on their own inputs. One cycle after a valid request, the block returns the verdict, the effective address and two flags for the next stage. The first flag says that the addressed word holds the real location of an inherited static field. The second says that the operand is a reference.

Top module: `opd_guard`

## Requirements
- R1: The descriptor word is split into these fields: bit 31 resolved, bit 30 read-only, bits [29:28] space selector, bits [27:24] kind, bits [23:22] visibility modifier and bits [21:0] byte offset.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. When there is no request, `rsp_grant` and `rsp_trap` are low. The fault, address and flag outputs keep their last values.
- R3: When the resolved bit is 0, the response carries fault code 1 (unresolved), `rsp_trap` is high and there is no grant.
- R4: Visibility modifier codes are 00 public, 01 private, 10 protected and 11 package. Requester relation codes are 00 unrelated, 01 same package, 10 subclass in another package and 11 same class. Private needs same class. Package needs same class or same package. Protected allows same class, same package or subclass. Public allows any relation. A violation gives fault code 2.
- R5: A write (`req_write`=1) to a descriptor whose read-only bit is set gives fault code 3. A read of the same descriptor is allowed.
- R6: When the kind field differs from `req_type`, the response carries fault code 4.
- R7: When several faults apply, only the one with the highest priority is reported: unresolved (1) first, then visibility (2), then read-only write (3), then kind mismatch (4). Code 0 means no fault.
- R8: The effective address is a base plus the zero-extended 22-bit offset, modulo 2^32. The base is `inst_base` for space selector 00 and `class_base` for 01, 10 and 11.
- R9: `rsp_indirect` is 1 when space selector bit 29 is set (an inherited static field), and 0 otherwise.
- R10: `rsp_is_ref` is 1 when the kind field equals 4'hF (reference), and 0 otherwise.
- R11: `rsp_grant` is 1 for a response exactly when its fault code is 0.
- R12: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_rel | input | 2 | Requester relation to the owning class |
| req_type | input | 4 | Operand kind the instruction expects |
| req_desc | input | 32 | Operand descriptor word |
| inst_base | input | 32 | Instance data space base address |
| class_base | input | 32 | Class data space base address |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Access granted |
| rsp_trap | output | 1 | Resolution trap request |
| rsp_fault | output | 3 | Prioritized fault code |
| rsp_addr | output | 32 | Effective address |
| rsp_indirect | output | 1 | Addressed word holds the real address |
| rsp_is_ref | output | 1 | Operand is a reference |

## Verification
The bench walks every pairing of visibility modifier and relation that sits on a boundary. A checker that mixed up the package and protected rules, or that treated a subclass as same-package, would grant or refuse the wrong row. It stacks two, three and four faults on one descriptor, so a priority encoder in the wrong order reports a lower-priority code. It also checks that a read of a read-only operand stays granted. For addressing, it uses the maximum offset, the two inherited static selector codes and a base that wraps past 2^32. A design that sign-extended the offset, picked the base from the wrong selector bit, or flagged indirection for the plain static code would produce a wrong address or flag.

// File: rtl/opd_pkg.sv
package opd_pkg;
   typedef enum logic [2:0] {
      FLT_NONE   = 3'd0,
      FLT_UNRES  = 3'd1,
      FLT_ACCESS = 3'd2,
      FLT_RDONLY = 3'd3,
      FLT_TYPE   = 3'd4
   } fault_e;

   typedef enum logic [1:0] {
      VIS_PUBLIC    = 2'b00,
      VIS_PRIVATE   = 2'b01,
      VIS_PROTECTED = 2'b10,
      VIS_PACKAGE   = 2'b11
   } vis_e;

   typedef enum logic [1:0] {
      REL_OTHER      = 2'b00,
      REL_SAME_PKG   = 2'b01,
      REL_SUBCLASS   = 2'b10,
      REL_SAME_CLASS = 2'b11
   } rel_e;
endpackage

// File: rtl/opd_field_split.sv
module opd_field_split #(
   parameter int DESC_W = 32,
   parameter int OFS_W  = 22,
   parameter int TYPE_W = 4
) (
   input  logic [DESC_W-1:0] desc,
   output logic              resolved,
   output logic              rdonly,
   output logic [1:0]        space,
   output logic [TYPE_W-1:0] kind,
   output logic [1:0]        vis,
   output logic [OFS_W-1:0]  ofs
);
   localparam int VIS_LO   = OFS_W;
   localparam int KIND_LO  = VIS_LO + 2;
   localparam int SPACE_LO = KIND_LO + TYPE_W;
   localparam int RO_BIT   = SPACE_LO + 2;
   localparam int RES_BIT  = RO_BIT + 1;

   generate
      if (RES_BIT != DESC_W - 1) begin : g_bad_layout
         $error("descriptor fields do not fill DESC_W");
      end
   endgenerate

   // R1: packed field extraction
   assign ofs      = desc[OFS_W-1:0];
   assign vis      = desc[VIS_LO+1:VIS_LO];
   assign kind     = desc[SPACE_LO-1:KIND_LO];
   assign space    = desc[RO_BIT-1:SPACE_LO];
   assign rdonly   = desc[RO_BIT];
   assign resolved = desc[RES_BIT];
endmodule

// File: rtl/opd_visibility.sv
module opd_visibility
   import opd_pkg::*;
#(
   parameter bit PROT_SPANS_PKG = 1'b1
) (
   input  logic [1:0] vis,
   input  logic [1:0] rel,
   output logic       allowed
);
   rel_e r;
   logic prot_ok;
   logic pkg_ok;

   assign r      = rel_e'(rel);
   assign pkg_ok = (r == REL_SAME_CLASS) || (r == REL_SAME_PKG);

   generate
      if (PROT_SPANS_PKG) begin : g_prot_wide
         assign prot_ok = pkg_ok || (r == REL_SUBCLASS);
      end else begin : g_prot_narrow
         assign prot_ok = (r == REL_SAME_CLASS) || (r == REL_SUBCLASS);
      end
   endgenerate

   always_comb begin
      unique case (vis_e'(vis))
         VIS_PUBLIC:    allowed = 1'b1;
         VIS_PRIVATE:   allowed = (r == REL_SAME_CLASS);
         VIS_PROTECTED: allowed = prot_ok;
         VIS_PACKAGE:   allowed = pkg_ok;
         default:       allowed = 1'b0;
      endcase
   end

   always_comb begin
      AST_PRIVATE_OUTSIDER: assert (!(vis == 2'b01 && rel != 2'b11 && allowed)); // R4
      AST_PUBLIC_OPEN: assert (!(vis == 2'b00 && !allowed)); // R4
   end
endmodule

// File: rtl/opd_fault_pick.sv
module opd_fault_pick
   import opd_pkg::*;
(
   input  logic   unres,
   input  logic   vis_bad,
   input  logic   ro_bad,
   input  logic   kind_bad,
   output fault_e code
);
   // R7: fixed priority, first match wins
   always_comb begin
      if (unres)         code = FLT_UNRES;
      else if (vis_bad)  code = FLT_ACCESS;
      else if (ro_bad)   code = FLT_RDONLY;
      else if (kind_bad) code = FLT_TYPE;
      else               code = FLT_NONE;
   end

   always_comb begin
      AST_UNRES_WINS: assert (!(unres && code != FLT_UNRES)); // R7
      AST_CLEAN_NONE: assert (!(!unres && !vis_bad && !ro_bad && !kind_bad && code != FLT_NONE)); // R7
   end
endmodule

// File: rtl/opd_ea_adder.sv
module opd_ea_adder #(
   parameter int OFS_W  = 22,
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFS_W-1:0]  ofs,
   output logic [ADDR_W-1:0] ea
);
   localparam int PAD_W = ADDR_W - OFS_W;

   generate
      if (ADDR_W < OFS_W) begin : g_bad_width
         $error("ADDR_W must be at least OFS_W");
      end else if (PAD_W == 0) begin : g_flush
         assign ea = base + ofs;
      end else begin : g_zext
         // R8: offset zero-extended, sum wraps modulo 2^ADDR_W
         assign ea = base + {{PAD_W{1'b0}}, ofs};
      end
   endgenerate
endmodule

// File: rtl/opd_guard.sv
module opd_guard
   import opd_pkg::*;
#(
   parameter int          DESC_W         = 32,
   parameter int          OFS_W          = 22,
   parameter int          TYPE_W         = 4,
   parameter int          ADDR_W         = 32,
   parameter logic [3:0]  REF_KIND       = 4'hF,
   parameter bit          PROT_SPANS_PKG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_rel,
   input  logic [TYPE_W-1:0] req_type,
   input  logic [DESC_W-1:0] req_desc,
   input  logic [ADDR_W-1:0] inst_base,
   input  logic [ADDR_W-1:0] class_base,
   output logic              rsp_valid,
   output logic              rsp_grant,
   output logic              rsp_trap,
   output logic [2:0]        rsp_fault,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_indirect,
   output logic              rsp_is_ref
);
   localparam logic [TYPE_W-1:0] REF_CODE = TYPE_W'(REF_KIND);

   generate
      if (TYPE_W < 1 || TYPE_W > 4) begin : g_bad_type
         $error("TYPE_W out of range");
      end
   endgenerate

   logic              f_res;
   logic              f_ro;
   logic [1:0]        f_space;
   logic [TYPE_W-1:0] f_kind;
   logic [1:0]        f_vis;
   logic [OFS_W-1:0]  f_ofs;
   logic              vis_ok;
   fault_e            code;
   logic [ADDR_W-1:0] sel_base;
   logic [ADDR_W-1:0] ea;

   opd_field_split #(.DESC_W(DESC_W), .OFS_W(OFS_W), .TYPE_W(TYPE_W)) i_split (
      .desc(req_desc), .resolved(f_res), .rdonly(f_ro), .space(f_space),
      .kind(f_kind), .vis(f_vis), .ofs(f_ofs)
   );

   opd_visibility #(.PROT_SPANS_PKG(PROT_SPANS_PKG)) i_vis (
      .vis(f_vis), .rel(req_rel), .allowed(vis_ok)
   );

   opd_fault_pick i_pick (
      .unres(!f_res), .vis_bad(!vis_ok), .ro_bad(f_ro && req_write),
      .kind_bad(f_kind != req_type), .code(code)
   );

   // R8: any non-zero selector points into the class data space
   assign sel_base = (f_space == 2'b00) ? inst_base : class_base;

   opd_ea_adder #(.OFS_W(OFS_W), .ADDR_W(ADDR_W)) i_ea (
      .base(sel_base), .ofs(f_ofs), .ea(ea)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_grant    <= 1'b0;
         rsp_trap     <= 1'b0;
         rsp_fault    <= 3'd0;
         rsp_addr     <= '0;
         rsp_indirect <= 1'b0;
         rsp_is_ref   <= 1'b0;
      end else begin
         rsp_valid <= req_valid;
         rsp_grant <= req_valid && (code == FLT_NONE);
         rsp_trap  <= req_valid && (code == FLT_UNRES);
         if (req_valid) begin
            rsp_fault    <= code;
            rsp_addr     <= ea;
            rsp_indirect <= f_space[1];
            rsp_is_ref   <= (f_kind == REF_CODE);
         end
      end
   end

   AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R2
   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !rsp_grant && !rsp_trap)); // R2
   AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_grant == (rsp_fault == 3'd0))); // R11
   AST_TRAP_UNRES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_desc[DESC_W-1]) |=> (rsp_trap && !rsp_grant)); // R3
   AST_RO_WRITE_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_desc[DESC_W-2]) |=> !rsp_grant); // R5
   AST_INDIRECT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_indirect == $past(req_desc[DESC_W-3]))); // R9
endmodule

// File: tb/test_opd_guard.sv
module test_opd_guard;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [1:0]  req_rel = 2'b00;
   logic [3:0]  req_type = 4'h0;
   logic [31:0] req_desc = 32'h0;
   logic [31:0] inst_base = 32'h0;
   logic [31:0] class_base = 32'h0;
   logic        rsp_valid, rsp_grant, rsp_trap, rsp_indirect, rsp_is_ref;
   logic [2:0]  rsp_fault;
   logic [31:0] rsp_addr;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   opd_guard i_opd_guard (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_rel(req_rel), .req_type(req_type), .req_desc(req_desc),
      .inst_base(inst_base), .class_base(class_base), .rsp_valid(rsp_valid),
      .rsp_grant(rsp_grant), .rsp_trap(rsp_trap), .rsp_fault(rsp_fault),
      .rsp_addr(rsp_addr), .rsp_indirect(rsp_indirect), .rsp_is_ref(rsp_is_ref)
   );

   localparam logic [31:0] IB = 32'h1000_0000;
   localparam logic [31:0] CB = 32'h2000_0000;

   typedef struct packed {
      logic        wr;
      logic [1:0]  rel;
      logic [3:0]  rt;
      logic [31:0] desc;   // {res, ro, space[1:0], kind[3:0], vis[1:0], ofs[21:0]}
      logic [2:0]  fault;
      logic [31:0] addr;
      logic        ind;
      logic        isref;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VEC [NV] = '{
      // R8 instance space, public read
      '{1'b0, 2'b00, 4'h2, {1'b1,1'b0,2'b00,4'h2,2'b00,22'h000010}, 3'd0, 32'h1000_0010, 1'b0, 1'b0},
      // R8 class space, max offset
      '{1'b0, 2'b00, 4'h2, {1'b1,1'b0,2'b01,4'h2,2'b00,22'h3FFFFF}, 3'd0, 32'h203F_FFFF, 1'b0, 1'b0},
      // R9 inherited static, selector 10
      '{1'b0, 2'b00, 4'h2, {1'b1,1'b0,2'b10,4'h2,2'b00,22'h000004}, 3'd0, 32'h2000_0004, 1'b1, 1'b0},
      // R9 inherited static, selector 11
      '{1'b0, 2'b00, 4'h2, {1'b1,1'b0,2'b11,4'h2,2'b00,22'h000008}, 3'd0, 32'h2000_0008, 1'b1, 1'b0},
      // R4 private, same class
      '{1'b0, 2'b11, 4'h2, {1'b1,1'b0,2'b00,4'h2,2'b01,22'h000010}, 3'd0, 32'h1000_0010, 1'b0, 1'b0},
      // R4 private, same package
      '{1'b0, 2'b01, 4'h2, {1'b1,1'b0,2'b00,4'h2,2'b01,22'h000010}, 3'd2, 32'h1000_0010, 1'b0, 1'b0},
      // R4 package, same package
      '{1'b0, 2'b01, 4'h2, {1'b1,1'b0,2'b00,4'h2,2'b11,22'h000010}, 3'd0, 32'h1000_0010, 1'b0, 1'b0},
      // R4 package, subclass elsewhere
      '{1'b0, 2'b10, 4'h2, {1'b1,1'b0,2'b00,4'h2,2'b11,22'h000010}, 3'd2, 32'h1000_0010, 1'b0, 1'b0},
      // R4 protected, subclass
      '{1'b0, 2'b10, 4'h2, {1'b1,1'b0,2'b00,4'h2,2'b10,22'h000010}, 3'd0, 32'h1000_0010, 1'b0, 1'b0},
      // R4 protected, unrelated
      '{1'b0, 2'b00, 4'h2, {1'b1,1'b0,2'b00,4'h2,2'b10,22'h000010}, 3'd2, 32'h1000_0010, 1'b0, 1'b0},
      // R4 protected, same package
      '{1'b0, 2'b01, 4'h2, {1'b1,1'b0,2'b00,4'h2,2'b10,22'h000010}, 3'd0, 32'h1000_0010, 1'b0, 1'b0},
      // R4 private, subclass
      '{1'b0, 2'b10, 4'h2, {1'b1,1'b0,2'b00,4'h2,2'b01,22'h000010}, 3'd2, 32'h1000_0010, 1'b0, 1'b0},
      // R5 write to read-only
      '{1'b1, 2'b00, 4'h2, {1'b1,1'b1,2'b00,4'h2,2'b00,22'h000010}, 3'd3, 32'h1000_0010, 1'b0, 1'b0},
      // R5 read of read-only
      '{1'b0, 2'b00, 4'h2, {1'b1,1'b1,2'b00,4'h2,2'b00,22'h000010}, 3'd0, 32'h1000_0010, 1'b0, 1'b0},
      // R5 write to writable
      '{1'b1, 2'b00, 4'h2, {1'b1,1'b0,2'b00,4'h2,2'b00,22'h000010}, 3'd0, 32'h1000_0010, 1'b0, 1'b0},
      // R6 kind mismatch
      '{1'b0, 2'b00, 4'h3, {1'b1,1'b0,2'b00,4'h2,2'b00,22'h000010}, 3'd4, 32'h1000_0010, 1'b0, 1'b0},
      // R7 all four faults, unresolved wins
      '{1'b1, 2'b00, 4'h3, {1'b0,1'b1,2'b00,4'h2,2'b01,22'h000010}, 3'd1, 32'h1000_0010, 1'b0, 1'b0},
      // R7 visibility beats read-only and kind
      '{1'b1, 2'b00, 4'h3, {1'b1,1'b1,2'b00,4'h2,2'b01,22'h000010}, 3'd2, 32'h1000_0010, 1'b0, 1'b0},
      // R7 read-only beats kind
      '{1'b1, 2'b00, 4'h3, {1'b1,1'b1,2'b00,4'h2,2'b00,22'h000010}, 3'd3, 32'h1000_0010, 1'b0, 1'b0},
      // R10 reference kind
      '{1'b0, 2'b00, 4'hF, {1'b1,1'b0,2'b01,4'hF,2'b00,22'h000020}, 3'd0, 32'h2000_0020, 1'b0, 1'b1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic issue(input logic wr, input logic [1:0] rel, input logic [3:0] rt,
                        input logic [31:0] desc);
      req_valid = 1'b1;
      req_write = wr;
      req_rel   = rel;
      req_type  = rt;
      req_desc  = desc;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      inst_base  = IB;
      class_base = CB;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 rsp_valid", {31'b0, rsp_valid}, 32'd0);
      chk("R12 rsp_grant", {31'b0, rsp_grant}, 32'd0);
      chk("R12 rsp_trap", {31'b0, rsp_trap}, 32'd0);
      chk("R12 rsp_fault", {29'b0, rsp_fault}, 32'd0);
      chk("R12 rsp_addr", rsp_addr, 32'd0);
      chk("R12 flags", {30'b0, rsp_indirect, rsp_is_ref}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk, back-to-back requests
      for (int i = 0; i < NV; i++) begin
         issue(VEC[i].wr, VEC[i].rel, VEC[i].rt, VEC[i].desc);
         @(negedge clk);
         chk("R2 rsp_valid", {31'b0, rsp_valid}, 32'd1);
         chk("R7 fault code", {29'b0, rsp_fault}, {29'b0, VEC[i].fault});
         chk("R11 grant", {31'b0, rsp_grant}, {31'b0, (VEC[i].fault == 3'd0)});
         chk("R8 address", rsp_addr, VEC[i].addr);
         chk("R9 indirect", {31'b0, rsp_indirect}, {31'b0, VEC[i].ind});
         chk("R10 is_ref", {31'b0, rsp_is_ref}, {31'b0, VEC[i].isref});
         chk("R3 trap", {31'b0, rsp_trap}, {31'b0, (VEC[i].fault == 3'd1)});
      end

      // R2 idle cycle: no valid, no grant, held address
      req_valid = 1'b0;
      @(negedge clk);
      chk("R2 idle valid", {31'b0, rsp_valid}, 32'd0);
      chk("R2 idle grant", {31'b0, rsp_grant}, 32'd0);
      chk("R2 idle held addr", rsp_addr, 32'h2000_0020);

      // R3 unresolved, otherwise clean: trap and no grant
      issue(1'b0, 2'b00, 4'h2, {1'b0,1'b0,2'b00,4'h2,2'b00,22'h000040});
      @(negedge clk);
      chk("R3 trap high", {31'b0, rsp_trap}, 32'd1);
      chk("R3 no grant", {31'b0, rsp_grant}, 32'd0);
      chk("R3 fault 1", {29'b0, rsp_fault}, 32'd1);

      // R8 base wrap past 2^32, R1 offset field confined to [21:0]
      inst_base = 32'hFFFF_FFF0;
      issue(1'b0, 2'b00, 4'h2, {1'b1,1'b0,2'b00,4'h2,2'b00,22'h000020});
      @(negedge clk);
      chk("R8 wrap", rsp_addr, 32'h0000_0010);
      chk("R1 grant", {31'b0, rsp_grant}, 32'd1);

      // R1 kind field position: kind 4'h5 matches, visibility bits 11 same class
      inst_base = IB;
      issue(1'b0, 2'b11, 4'h5, 32'hA5C0_0001);
      @(negedge clk);
      chk("R1 fields grant", {31'b0, rsp_grant}, 32'd1);
      chk("R1 fields addr", rsp_addr, 32'h2000_0001);
      chk("R1 fields indirect", {31'b0, rsp_indirect}, 32'd1);
      req_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule